// File: doc/BRIEF.md
# Protection Fault Manager for an H-Bridge Driver

This block collects the protection flags of a motor bridge driver: overcurrent, overtemperature, overvoltage, stall and the indication that the bridge is regulating its current cycle by cycle. For each class it decides two things. The first is whether the bridge must be switched off. The second is whether the active-low open-drain fault pin is pulled low. Detection of the events happens elsewhere, and the configuration bits come from a register bank outside this block.

Overcurrent and overtemperature each have a response mode. In one mode the fault is held until software clears it. In the other mode the block recovers by itself. Overcurrent recovers after a retry interval counted in clock cycles. Overtemperature recovers once the die has cooled below its threshold minus hysteresis. A write strobe to the clear bit produces a one-cycle clear pulse. That pulse releases every held fault whose condition has gone away. Overvoltage can be disabled. Stall and cycle-by-cycle reporting can each be kept off the fault pin. Neither of them ever switches off the bridge.

Top module: `fault_manager`

## Requirements
- R1: After reset, shutdown_req is 0, fault_n is 1 and clr_bit is 0.
- R2: With oc_auto_retry = 0, an oc_flag sampled high at a clock edge sets shutdown_req to 1 and fault_n to 0 after that edge. Both stay in that state until a clear releases them, however long oc_flag stays low.
- R3: With oc_auto_retry = 1, shutdown_req and fault_n stay asserted for exactly RETRY_CYCLES cycles after the last edge at which oc_flag was sampled high. Each new overcurrent sample restarts the interval.
- R4: With ot_auto_retry = 0, an ot_flag sampled high holds shutdown_req = 1 and fault_n = 0 until a clear releases it.
- R5: With ot_auto_retry = 1, the overtemperature shutdown stays asserted until an edge at which ot_flag is low and ot_cooled is high. It is released after that edge. While ot_cooled is low, the shutdown stays asserted.
- R6: A one-cycle clr_write strobe makes clr_bit 1 for exactly one cycle, after which clr_bit returns to 0 by itself. At the following edge, every held fault whose flag is low at that edge is released.
- R7: A clear has no effect on a held fault whose flag is still high during the clear pulse. That fault stays held after the flag drops, until a later clear.
- R8: With ov_enable = 1, ov_flag drives shutdown_req = 1 and fault_n = 0 one cycle later, for as long as it stays high, without holding. With ov_enable = 0, ov_flag has no effect on either output.
- R9: With stall_report = 1, stall_flag drives fault_n low one cycle later. With stall_report = 0, stall_flag has no effect on fault_n. A stall never sets shutdown_req.
- R10: fault_n goes low one cycle after cbc_active is high only when both cbc_report = 1 and cbc_reg_mode = 1. In that case cbc_active never sets shutdown_req. If either enable bit is 0, cbc_active has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| oc_flag | input | 1 | Overcurrent detected |
| ot_flag | input | 1 | Overtemperature detected |
| ot_cooled | input | 1 | Temperature is below threshold minus hysteresis |
| ov_flag | input | 1 | Overvoltage detected |
| stall_flag | input | 1 | Motor stall detected |
| cbc_active | input | 1 | Bridge is in internal current regulation |
| oc_auto_retry | input | 1 | Overcurrent response: 0 hold, 1 timed retry |
| ot_auto_retry | input | 1 | Overtemperature response: 0 hold, 1 retry on cooling |
| ov_enable | input | 1 | Overvoltage protection enable |
| stall_report | input | 1 | Report stall on the fault pin |
| cbc_report | input | 1 | Report cycle-by-cycle regulation on the fault pin |
| cbc_reg_mode | input | 1 | Current regulation is in cycle-by-cycle mode |
| clr_write | input | 1 | Write strobe of 1 to the clear bit |
| clr_bit | output | 1 | Self-clearing clear bit (readback) |
| shutdown_req | output | 1 | Request to switch the bridge off |
| fault_n | output | 1 | Fault pin, active low |

## Verification
On every cycle, the assertions check the one-cycle response of the outputs to each enabled flag: overcurrent, overtemperature, enabled overvoltage, reported stall and reported regulation. They also check that the clear bit lasts one cycle only and that a shutdown always pulls the fault pin low. Other behaviours can only be shown by the directed scenarios. These are the exact length of the retry interval and its restart, the hold-until-clear behaviour, and clears that are ignored because the flag is still high. The scenarios also cover release on cooling and the cases where a disabled or unreported flag leaves both outputs untouched.

// File: rtl/fm_pkg.sv
package fm_pkg;

    // Registered top-level outputs of the fault manager.
    typedef struct packed {
        logic clr;
        logic shutdown;
        logic fault_n;
    } fm_top_state_t;

    localparam fm_top_state_t FM_TOP_RESET = '{clr: 1'b0, shutdown: 1'b0, fault_n: 1'b1};

endpackage

// File: rtl/fm_fault_unit.sv
// One protection class with a hold-or-recover response.
// TIMED = 1: recovery after RETRY_CYCLES quiet cycles (release_in qualifies it).
// TIMED = 0: recovery when release_in is seen with the flag low.
module fm_fault_unit #(
    parameter bit TIMED        = 1'b1,
    parameter int RETRY_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_in,
    input  logic retry_mode,
    input  logic clr_pulse,
    input  logic release_in,
    output logic engaged_d
);
    localparam int CW = (RETRY_CYCLES > 1) ? $clog2(RETRY_CYCLES) : 1;

    typedef struct packed {
        logic          held;
        logic          retry;
        logic [CW-1:0] cnt;
    } unit_state_t;

    unit_state_t st_d, st_q;
    logic        rel;

    generate
        if (TIMED) begin : g_timer
            localparam logic [CW-1:0] LAST = CW'(RETRY_CYCLES - 1);
            assign rel = (st_q.cnt == LAST) && release_in;
        end else begin : g_external
            assign rel = release_in;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (fault_in) begin
            if (retry_mode) begin
                st_d.retry = 1'b1;
                st_d.cnt   = '0;
            end else begin
                st_d.held = 1'b1;
            end
        end else if (st_q.retry) begin
            if (rel) begin
                st_d.retry = 1'b0;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        // a clear only releases a hold whose cause has gone away
        if (clr_pulse && !fault_in) begin
            st_d.held = 1'b0;
        end
        engaged_d = st_d.held | st_d.retry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/fm_pin_merge.sv
// Combines shutdown causes and report-only causes into the next output values.
module fm_pin_merge #(
    parameter int N_SD  = 3,
    parameter int N_RPT = 2
) (
    input  logic [N_SD-1:0]  sd_terms,
    input  logic [N_RPT-1:0] rpt_terms,
    output logic             shutdown_d,
    output logic             fault_n_d
);
    always_comb begin
        shutdown_d = |sd_terms;
        fault_n_d  = !(shutdown_d || (|rpt_terms));
    end
endmodule

// File: rtl/fault_manager.sv
module fault_manager
    import fm_pkg::*;
#(
    parameter int RETRY_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_flag,
    input  logic ot_flag,
    input  logic ot_cooled,
    input  logic ov_flag,
    input  logic stall_flag,
    input  logic cbc_active,
    input  logic oc_auto_retry,
    input  logic ot_auto_retry,
    input  logic ov_enable,
    input  logic stall_report,
    input  logic cbc_report,
    input  logic cbc_reg_mode,
    input  logic clr_write,
    output logic clr_bit,
    output logic shutdown_req,
    output logic fault_n
);
    localparam int N_SD  = 3;
    localparam int N_RPT = 2;

    fm_top_state_t st_d, st_q;
    logic          oc_engaged, ot_engaged;
    logic          sd_next, fn_next;
    logic [N_SD-1:0]  sd_terms;
    logic [N_RPT-1:0] rpt_terms;

    fm_fault_unit #(.TIMED(1'b1), .RETRY_CYCLES(RETRY_CYCLES)) u_oc (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_in   (oc_flag),
        .retry_mode (oc_auto_retry),
        .clr_pulse  (st_q.clr),
        .release_in (1'b1),
        .engaged_d  (oc_engaged)
    );

    fm_fault_unit #(.TIMED(1'b0), .RETRY_CYCLES(RETRY_CYCLES)) u_ot (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_in   (ot_flag),
        .retry_mode (ot_auto_retry),
        .clr_pulse  (st_q.clr),
        .release_in (ot_cooled),
        .engaged_d  (ot_engaged)
    );

    assign sd_terms  = {ov_enable & ov_flag, ot_engaged, oc_engaged};
    assign rpt_terms = {cbc_report & cbc_reg_mode & cbc_active, stall_report & stall_flag};

    fm_pin_merge #(.N_SD(N_SD), .N_RPT(N_RPT)) u_merge (
        .sd_terms   (sd_terms),
        .rpt_terms  (rpt_terms),
        .shutdown_d (sd_next),
        .fault_n_d  (fn_next)
    );

    always_comb begin
        st_d          = st_q;
        st_d.clr      = clr_write;   // one cycle per strobe, then back to 0
        st_d.shutdown = sd_next;
        st_d.fault_n  = fn_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= FM_TOP_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign clr_bit      = st_q.clr;
    assign shutdown_req = st_q.shutdown;
    assign fault_n      = st_q.fault_n;

endmodule

// File: rtl/fault_manager_chk.sv
module fault_manager_chk (
    input logic clk,
    input logic rst_n,
    input logic oc_flag,
    input logic ot_flag,
    input logic ov_flag,
    input logic ov_enable,
    input logic stall_flag,
    input logic stall_report,
    input logic cbc_active,
    input logic cbc_report,
    input logic cbc_reg_mode,
    input logic clr_write,
    input logic clr_bit,
    input logic shutdown_req,
    input logic fault_n
);
    // R2
    oc_shuts_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oc_flag |=> shutdown_req);

    // R4
    ot_shuts_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ot_flag |=> shutdown_req);

    // R6
    clr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_write |=> clr_bit);

    // R6
    clr_self_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_bit && !clr_write) |=> !clr_bit);

    // R8
    ov_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_flag && ov_enable) |=> (shutdown_req && !fault_n));

    // R9
    stall_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_flag && stall_report) |=> !fault_n);

    // R10
    cbc_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cbc_active && cbc_report && cbc_reg_mode) |=> !fault_n);

    // R2
    shutdown_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> !fault_n);

endmodule

bind fault_manager fault_manager_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .oc_flag      (oc_flag),
    .ot_flag      (ot_flag),
    .ov_flag      (ov_flag),
    .ov_enable    (ov_enable),
    .stall_flag   (stall_flag),
    .stall_report (stall_report),
    .cbc_active   (cbc_active),
    .cbc_report   (cbc_report),
    .cbc_reg_mode (cbc_reg_mode),
    .clr_write    (clr_write),
    .clr_bit      (clr_bit),
    .shutdown_req (shutdown_req),
    .fault_n      (fault_n)
);

// File: tb/fault_manager_bench.sv
module fault_manager_bench;
    localparam int RC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oc_flag = 0, ot_flag = 0, ot_cooled = 0, ov_flag = 0, stall_flag = 0, cbc_active = 0;
    logic oc_auto_retry = 0, ot_auto_retry = 0, ov_enable = 0, stall_report = 0;
    logic cbc_report = 0, cbc_reg_mode = 0, clr_write = 0;
    logic clr_bit, shutdown_req, fault_n;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    fault_manager #(.RETRY_CYCLES(RC)) u_fault_manager (
        .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag), .ot_flag(ot_flag), .ot_cooled(ot_cooled),
        .ov_flag(ov_flag), .stall_flag(stall_flag), .cbc_active(cbc_active),
        .oc_auto_retry(oc_auto_retry), .ot_auto_retry(ot_auto_retry), .ov_enable(ov_enable),
        .stall_report(stall_report), .cbc_report(cbc_report), .cbc_reg_mode(cbc_reg_mode),
        .clr_write(clr_write), .clr_bit(clr_bit), .shutdown_req(shutdown_req), .fault_n(fault_n)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic do_clear();
        clr_write = 1'b1;
        step(1);
        clr_write = 1'b0;
        step(1);
    endtask

    task automatic t_reset();
        chk("R1 shutdown_req", shutdown_req, 1'b0);
        chk("R1 fault_n", fault_n, 1'b1);
        chk("R1 clr_bit", clr_bit, 1'b0);
    endtask

    task automatic t_oc_latched();
        oc_auto_retry = 0;
        oc_flag = 1; step(1); oc_flag = 0;
        chk("R2 shutdown on oc", shutdown_req, 1'b1);
        chk("R2 pin on oc", fault_n, 1'b0);
        step(RC + 5);
        chk("R2 still held", shutdown_req, 1'b1);
        chk("R2 pin still held", fault_n, 1'b0);
        clr_write = 1'b1; step(1); clr_write = 1'b0;
        chk("R6 clr_bit set", clr_bit, 1'b1);
        step(1);
        chk("R6 clr_bit self-clears", clr_bit, 1'b0);
        chk("R6 oc released", shutdown_req, 1'b0);
        chk("R6 pin released", fault_n, 1'b1);
    endtask

    task automatic t_oc_retry();
        oc_auto_retry = 1;
        oc_flag = 1; step(1); oc_flag = 0;
        chk("R3 shutdown on oc", shutdown_req, 1'b1);
        step(RC - 1);
        chk("R3 held until last cycle", shutdown_req, 1'b1);
        step(1);
        chk("R3 released after interval", shutdown_req, 1'b0);
        chk("R3 pin released", fault_n, 1'b1);
        oc_flag = 1; step(1); oc_flag = 0;
        step(3);
        oc_flag = 1; step(1); oc_flag = 0;
        step(RC - 1);
        chk("R3 restart extends", shutdown_req, 1'b1);
        step(1);
        chk("R3 released after restart", shutdown_req, 1'b0);
        oc_auto_retry = 0;
    endtask

    task automatic t_clear_active();
        oc_auto_retry = 0;
        oc_flag = 1; step(1);
        do_clear();
        chk("R7 clear ignored while active", shutdown_req, 1'b1);
        oc_flag = 0; step(3);
        chk("R7 still held after flag drops", shutdown_req, 1'b1);
        chk("R7 pin still held", fault_n, 1'b0);
        do_clear();
        chk("R7 later clear releases", shutdown_req, 1'b0);
    endtask

    task automatic t_ot_latched();
        ot_auto_retry = 0; ot_cooled = 1;
        ot_flag = 1; step(1); ot_flag = 0;
        step(4);
        chk("R4 ot held", shutdown_req, 1'b1);
        chk("R4 ot pin held", fault_n, 1'b0);
        do_clear();
        chk("R4 ot cleared", shutdown_req, 1'b0);
        ot_cooled = 0;
    endtask

    task automatic t_ot_retry();
        ot_auto_retry = 1; ot_cooled = 0;
        ot_flag = 1; step(1); ot_flag = 0;
        step(RC + 4);
        chk("R5 held while hot", shutdown_req, 1'b1);
        ot_cooled = 1; step(1);
        chk("R5 released on cooling", shutdown_req, 1'b0);
        chk("R5 pin released", fault_n, 1'b1);
        ot_flag = 1; step(1);
        chk("R5 held while flag high", shutdown_req, 1'b1);
        ot_flag = 0; step(1);
        chk("R5 released when flag drops", shutdown_req, 1'b0);
        ot_cooled = 0; ot_auto_retry = 0;
    endtask

    task automatic t_ov();
        ov_enable = 1; ov_flag = 1; step(1);
        chk("R8 ov shutdown", shutdown_req, 1'b1);
        chk("R8 ov pin", fault_n, 1'b0);
        ov_flag = 0; step(1);
        chk("R8 ov not held", shutdown_req, 1'b0);
        chk("R8 ov pin not held", fault_n, 1'b1);
        ov_enable = 0; ov_flag = 1; step(2);
        chk("R8 ov disabled shutdown", shutdown_req, 1'b0);
        chk("R8 ov disabled pin", fault_n, 1'b1);
        ov_flag = 0; step(1);
    endtask

    task automatic t_stall();
        stall_report = 1; stall_flag = 1; step(1);
        chk("R9 stall reported", fault_n, 1'b0);
        chk("R9 stall no shutdown", shutdown_req, 1'b0);
        stall_report = 0; step(1);
        chk("R9 stall unreported", fault_n, 1'b1);
        stall_flag = 0; step(1);
    endtask

    task automatic t_cbc();
        cbc_report = 1; cbc_reg_mode = 1; cbc_active = 1; step(1);
        chk("R10 cbc reported", fault_n, 1'b0);
        chk("R10 cbc no shutdown", shutdown_req, 1'b0);
        cbc_reg_mode = 0; step(1);
        chk("R10 cbc other mode", fault_n, 1'b1);
        cbc_reg_mode = 1; cbc_report = 0; step(1);
        chk("R10 cbc unreported", fault_n, 1'b1);
        cbc_active = 0; cbc_reg_mode = 0; step(1);
    endtask

    initial begin
        #400000;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        step(2);
        t_reset();
        rst_n = 1'b1;
        step(1);
        t_oc_latched();
        t_oc_retry();
        t_clear_active();
        t_ot_latched();
        t_ot_retry();
        t_ov();
        t_stall();
        t_cbc();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule